// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Plane

This block is the programmable logic core in front of ten output cells. Twenty-two input signals (dedicated pins plus feedback) are each offered to the plane twice, once as-is and once inverted, which gives 44 columns. Every row of the plane is a product term: the AND of the columns whose stored connection bit is set. Rows are grouped so that each output gets its own OR-ed group of logic terms, one term used only as that output's drive enable, and two further terms shared by every register: one for asynchronous clear and one for synchronous preset.

The connection bits live in a register store that is loaded one row at a time through a parallel configuration port, gated by a configuration enable. A bulk erase clears the whole store. Evaluation of the plane is combinational: a change on the input signals reaches the sums and enables without any clock edge. The outputs leave this block as sums, enables and the two global terms, and the output cells downstream decide how to use them.

Top module: `sop_plane`

## Requirements
- R1: After reset every connection bit is cleared, so all ten sums read 0, all ten enables read 1, and both global terms read 0.
- R2: Connection bit number row*44 + col is bit col of the row written at address row; column 2*s is input s as-is and column 2*s+1 is input s inverted.
- R3: A product term is the AND of its connected columns; a term that connects both polarities of one input, or all 44 columns, is always 0.
- R4: A term with no connected columns gives 0 when it feeds a sum or a global term, and 1 when it is an enable term.
- R5: Output k (k = 0..9) ORs a group of 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 logic terms respectively.
- R6: Row order is fixed: row 0 is the asynchronous clear term, then for each output from 0 to 9 its enable row followed by its logic rows, and row 131 is the synchronous preset term.
- R7: Row writes and erase requests have no effect while the configuration enable is low.
- R8: A row write to an address of 132 or above changes no stored bit.
- R9: An erase request with the configuration enable high clears every row at the next clock edge.
- R10: Sums, enables and global terms follow the input signals with no clock edge; a row write takes effect at the clock edge that samples it.
- R11: When a row write and an erase arrive in the same cycle, the erase wins and the written row ends up cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset, clears the store |
| cfgEn | input | 1 | Configuration enable; writes and erase are ignored when low |
| cfgWe | input | 1 | Row write request |
| cfgErase | input | 1 | Erase-all request |
| cfgRow | input | 8 | Row address of a write |
| cfgData | input | 44 | Connection bits of the addressed row |
| sigIn | input | 22 | Input signals to the plane |
| sumOut | output | 10 | OR of each output's logic terms |
| oeOut | output | 10 | Enable term of each output |
| arstTerm | output | 1 | Shared asynchronous clear term |
| spreTerm | output | 1 | Shared synchronous preset term |

## Verification
The bench programs single terms at the edges of the row layout: the last logic row of the fifth output, the first logic row of the sixth, the last logic row of the final output and both global rows, so a wrong group size or an off-by-one in row placement moves a term into the wrong sum and the table of input patterns shows it. Terms that connect a signal with its own inverse or every column must read 0, which catches a plane that treats "all connected" as empty. Empty enable rows must read 1 while empty logic rows read 0; a design that picks one default for both fails the reset check. Writes with the enable low, to addresses past the last row, and writes colliding with an erase are each followed by an output check that would show a stray term.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Strobes from configuration control to the store
  typedef struct packed {
    logic rowWe;
    logic eraseAll;
  } cfgStrobe_t;

  // Number of logic terms of output k: rises by step toward the middle, then falls
  function automatic int ptCount(int k, int nOut, int base, int step);
    int m;
    m = (k < nOut - 1 - k) ? k : (nOut - 1 - k);
    return base + step * m;
  endfunction

  // Row index of output k's enable term; k == nOut yields the preset row
  function automatic int enRow(int k, int nOut, int base, int step);
    int r;
    r = 1;
    for (int j = 0; j < k; j++) r += 1 + ptCount(j, nOut, base, step);
    return r;
  endfunction

  function automatic int rowTotal(int nOut, int base, int step);
    return enRow(nOut, nOut, base, step) + 1;
  endfunction

endpackage

// File: rtl/sop_cfg_ctrl.sv
module sop_cfg_ctrl #(
  parameter int NUM_ROWS = 132,
  parameter int ROW_AW   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfgEn,
  input  logic                  cfgWe,
  input  logic                  cfgErase,
  input  logic [ROW_AW-1:0]     cfgRow,
  output sop_pkg::cfgStrobe_t   strobe
);

  logic rowInRange;

  assign rowInRange = (int'(cfgRow) < NUM_ROWS);

  always_comb begin
    strobe          = '0;
    strobe.eraseAll = cfgEn & cfgErase;
    // erase has priority over a row write in the same cycle
    strobe.rowWe    = cfgEn & cfgWe & ~cfgErase & rowInRange;
  end

  // R11: erase and write never fire together
  assert_erase_over_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgErase && cfgWe) |-> !strobe.rowWe);

endmodule

// File: rtl/sop_fuse_store.sv
module sop_fuse_store #(
  parameter int NUM_ROWS = 132,
  parameter int NUM_COL  = 44,
  parameter int ROW_AW   = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  sop_pkg::cfgStrobe_t            strobe,
  input  logic [ROW_AW-1:0]              rowIdx,
  input  logic [NUM_COL-1:0]             rowData,
  output logic [NUM_ROWS*NUM_COL-1:0]    maskFlat
);

  logic [NUM_COL-1:0] mem [NUM_ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_ROWS; r++) mem[r] <= '0;
    end else if (strobe.eraseAll) begin
      for (int r = 0; r < NUM_ROWS; r++) mem[r] <= '0;
    end else if (strobe.rowWe) begin
      mem[rowIdx] <= rowData;
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_flat
    assign maskFlat[r*NUM_COL +: NUM_COL] = mem[r];
  end

  // R8: a write strobe only reaches the store for an existing row
  assert_row_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.rowWe |-> (int'(rowIdx) < NUM_ROWS));

  // R2: the addressed row holds exactly the written bits
  assert_row_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe.rowWe) |-> (mem[$past(rowIdx)] == $past(rowData)));

  // R9: an erase leaves every row empty
  assert_erase_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe.eraseAll) |-> (maskFlat == '0));

endmodule

// File: rtl/sop_term_eval.sv
module sop_term_eval #(
  parameter int NUM_SIG  = 22,
  parameter int NUM_OUT  = 10,
  parameter int BASE_PT  = 8,
  parameter int PT_STEP  = 2,
  parameter int NUM_COL  = 2 * NUM_SIG,
  parameter int NUM_ROWS = sop_pkg::rowTotal(NUM_OUT, BASE_PT, PT_STEP)
) (
  input  logic [NUM_SIG-1:0]          sigIn,
  input  logic [NUM_ROWS*NUM_COL-1:0] maskFlat,
  output logic [NUM_OUT-1:0]          sumOut,
  output logic [NUM_OUT-1:0]          oeOut,
  output logic                        arstTerm,
  output logic                        spreTerm
);

  localparam int PRESET_ROW = NUM_ROWS - 1;

  logic [NUM_COL-1:0]  colVec;
  logic [NUM_ROWS-1:0] rowHit;
  logic [NUM_ROWS-1:0] rowEmpty;

  // even column: signal as-is, odd column: inverted
  for (genvar s = 0; s < NUM_SIG; s++) begin : g_col
    assign colVec[2*s]   = sigIn[s];
    assign colVec[2*s+1] = ~sigIn[s];
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    logic [NUM_COL-1:0] rowMask;
    assign rowMask     = maskFlat[r*NUM_COL +: NUM_COL];
    assign rowEmpty[r] = (rowMask == '0);
    assign rowHit[r]   = ~rowEmpty[r] & (&(colVec | ~rowMask));
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    localparam int EN_ROW = sop_pkg::enRow(k, NUM_OUT, BASE_PT, PT_STEP);
    localparam int PT_CNT = sop_pkg::ptCount(k, NUM_OUT, BASE_PT, PT_STEP);
    assign oeOut[k]  = rowEmpty[EN_ROW] | rowHit[EN_ROW];
    assign sumOut[k] = |rowHit[EN_ROW+1 +: PT_CNT];
  end

  assign arstTerm = rowHit[0];
  assign spreTerm = rowHit[PRESET_ROW];

endmodule

// File: rtl/sop_plane.sv
module sop_plane #(
  parameter int  NUM_SIG  = 22,
  parameter int  NUM_OUT  = 10,
  parameter int  BASE_PT  = 8,
  parameter int  PT_STEP  = 2,
  localparam int NUM_COL  = 2 * NUM_SIG,
  localparam int NUM_ROWS = sop_pkg::rowTotal(NUM_OUT, BASE_PT, PT_STEP),
  localparam int ROW_AW   = $clog2(NUM_ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgEn,
  input  logic               cfgWe,
  input  logic               cfgErase,
  input  logic [ROW_AW-1:0]  cfgRow,
  input  logic [NUM_COL-1:0] cfgData,
  input  logic [NUM_SIG-1:0] sigIn,
  output logic [NUM_OUT-1:0] sumOut,
  output logic [NUM_OUT-1:0] oeOut,
  output logic               arstTerm,
  output logic               spreTerm
);

  sop_pkg::cfgStrobe_t          strobe;
  logic [NUM_ROWS*NUM_COL-1:0]  maskFlat;

  sop_cfg_ctrl #(.NUM_ROWS(NUM_ROWS), .ROW_AW(ROW_AW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgEn(cfgEn), .cfgWe(cfgWe),
    .cfgErase(cfgErase), .cfgRow(cfgRow), .strobe(strobe)
  );

  sop_fuse_store #(.NUM_ROWS(NUM_ROWS), .NUM_COL(NUM_COL), .ROW_AW(ROW_AW)) i_store (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rowIdx(cfgRow),
    .rowData(cfgData), .maskFlat(maskFlat)
  );

  sop_term_eval #(
    .NUM_SIG(NUM_SIG), .NUM_OUT(NUM_OUT), .BASE_PT(BASE_PT), .PT_STEP(PT_STEP),
    .NUM_COL(NUM_COL), .NUM_ROWS(NUM_ROWS)
  ) i_eval (
    .sigIn(sigIn), .maskFlat(maskFlat), .sumOut(sumOut), .oeOut(oeOut),
    .arstTerm(arstTerm), .spreTerm(spreTerm)
  );

  // R7: with the enable low in the previous cycle the store is unchanged
  assert_frozen_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfgEn) |-> $stable(maskFlat));

endmodule

// File: tb/test_sop_plane.sv
`timescale 1ns/1ps
module test_sop_plane;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgEn = 1'b0;
  logic        cfgWe = 1'b0;
  logic        cfgErase = 1'b0;
  logic [7:0]  cfgRow = '0;
  logic [43:0] cfgData = '0;
  logic [21:0] sigIn = '0;
  logic [9:0]  sumOut;
  logic [9:0]  oeOut;
  logic        arstTerm;
  logic        spreTerm;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sop_plane i_sop_plane (
    .clk(clk), .rst_n(rst_n), .cfgEn(cfgEn), .cfgWe(cfgWe), .cfgErase(cfgErase),
    .cfgRow(cfgRow), .cfgData(cfgData), .sigIn(sigIn), .sumOut(sumOut),
    .oeOut(oeOut), .arstTerm(arstTerm), .spreTerm(spreTerm)
  );

  // {sig[21:0], sum[9:0], oe[9:0], arst, spre} for the programmed pattern:
  // sum0 = s0|~s1, oe0 = s2, sum4 = s3&s4, sum5 = 0, sum9 = s21, oe9 = 0,
  // arst = ~s6, spre = s7&s8, other sums 0 and other enables 1
  localparam logic [43:0] VEC [6] = '{
    {22'h000000, 10'h001, 10'h1FE, 1'b1, 1'b0},
    {22'h3FFFFF, 10'h211, 10'h1FF, 1'b0, 1'b1},
    {22'h000002, 10'h000, 10'h1FE, 1'b1, 1'b0},
    {22'h00001C, 10'h011, 10'h1FF, 1'b1, 1'b0},
    {22'h2000C2, 10'h200, 10'h1FE, 1'b0, 1'b0},
    {22'h00018B, 10'h001, 10'h1FE, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeRow(input logic en, input logic [7:0] row, input logic [43:0] data,
                          input logic erase);
    @(negedge clk);
    cfgEn = en; cfgWe = 1'b1; cfgRow = row; cfgData = data; cfgErase = erase;
    @(negedge clk);
    cfgEn = 1'b0; cfgWe = 1'b0; cfgErase = 1'b0; cfgData = '0;
  endtask

  task automatic applySig(input logic [21:0] s);
    sigIn = s;
    #1;
  endtask

  function automatic logic [23:0] outs();
    return {sumOut, oeOut, arstTerm, spreTerm};
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R4: empty store
    applySig(22'h3FFFFF);
    check("R1 reset outputs", 64'(outs()), 64'({10'h000, 10'h3FF, 1'b0, 1'b0}));
    applySig(22'h000000);
    check("R4 empty rows", 64'(outs()), 64'({10'h000, 10'h3FF, 1'b0, 1'b0}));

    // R7: write with enable low: row 0 would make arst = s0
    writeRow(1'b0, 8'd0, 44'h1, 1'b0);
    applySig(22'h000001);
    check("R7 disabled write", 64'(arstTerm), 64'(1'b0));

    // program the pattern (R2, R6 row layout)
    writeRow(1'b1, 8'd1,   44'h10, 1'b0);           // out0 enable: s2
    writeRow(1'b1, 8'd2,   44'h1, 1'b0);            // out0 logic: s0
    writeRow(1'b1, 8'd3,   44'h8, 1'b0);            // out0 logic: ~s1
    writeRow(1'b1, 8'd65,  44'h140, 1'b0);          // out4 last logic: s3&s4 (R5)
    writeRow(1'b1, 8'd67,  44'hFFFFFFFFFFF, 1'b0);  // out5 first logic: all columns (R3)
    writeRow(1'b1, 8'd122, 44'hC00, 1'b0);          // out9 enable: s5&~s5 (R3)
    writeRow(1'b1, 8'd130, 44'h40000000000, 1'b0);  // out9 last logic: s21
    writeRow(1'b1, 8'd0,   44'h2000, 1'b0);         // clear term: ~s6 (R6)
    writeRow(1'b1, 8'd131, 44'h14000, 1'b0);        // preset term: s7&s8 (R6)

    // table walk, no clock edge between input change and sample (R10)
    for (int i = 0; i < 6; i++) begin
      applySig(VEC[i][43:22]);
      check("R5 R3 R6 R10 vector", 64'(outs()), 64'(VEC[i][21:0]));
    end

    // R8: out-of-range addresses must not alias into real rows
    writeRow(1'b1, 8'd132, 44'hFFFFFFFFFFF, 1'b0);
    writeRow(1'b1, 8'd200, 44'h0, 1'b0);
    writeRow(1'b1, 8'd255, 44'h0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      applySig(VEC[i][43:22]);
      check("R8 ignored address", 64'(outs()), 64'(VEC[i][21:0]));
    end

    // R10: write takes effect at its edge; before that output still old
    @(negedge clk);
    sigIn = 22'h000040;
    cfgEn = 1'b1; cfgWe = 1'b1; cfgRow = 8'd0; cfgData = 44'h1000; // row 0: s6
    #1;
    check("R10 before edge", 64'(arstTerm), 64'(1'b0));
    @(negedge clk);
    cfgEn = 1'b0; cfgWe = 1'b0;
    #1;
    check("R10 after edge", 64'(arstTerm), 64'(1'b1));

    // R9: erase-all
    writeRow(1'b1, 8'd0, 44'h0, 1'b0);
    @(negedge clk);
    cfgEn = 1'b1; cfgErase = 1'b1;
    @(negedge clk);
    cfgEn = 1'b0; cfgErase = 1'b0;
    applySig(22'h3FFFFF);
    check("R9 erase all", 64'(outs()), 64'({10'h000, 10'h3FF, 1'b0, 1'b0}));

    // R11: erase together with a write leaves the row empty
    writeRow(1'b1, 8'd131, 44'h1, 1'b1);
    applySig(22'h000001);
    check("R11 erase wins", 64'(spreTerm), 64'(1'b0));

    // R7: erase with enable low keeps content
    writeRow(1'b1, 8'd131, 44'h1, 1'b0);
    @(negedge clk);
    cfgErase = 1'b1;
    @(negedge clk);
    cfgErase = 1'b0;
    #1;
    check("R7 disabled erase", 64'(spreTerm), 64'(1'b1));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule